// File: doc/BRIEF.md
# Burst SRAM with Selectable Burst Order

This block is a synthesizable model of a synchronous single-port static memory with a load/advance command interface. On each clock edge that is not masked, the memory either takes in a fresh command (a read, a write or a deselect) together with an address, or it steps a 2-bit burst counter that walks through the two lowest address bits of the last loaded address. The walk follows one of two orders, chosen by a static mode pin. In interleaved order the start address is XORed with the count. In linear order the count is added modulo four.

Write data is taken one clock after the command that addresses it. Four lane enables pick which bytes of the word are stored. Read data flows straight out of the array from the registered address. It is qualified by an asynchronous output enable. The bidirectional data pins are modelled as a separate output word and a drive-enable flag.

A snooze input puts the device into a retained, idle state. After snooze ends, the first enabled cycle may not carry a write. Such a write is dropped and a flag is raised.

Top module: `bsram_top`

## Requirements
- R1: After synchronous reset, `dq_oe` is 0, `rdata` is all zeros and `wr_err` is 0. Every stored word reads as zero.
- R2: A load (`adv`=0) with `rd_wr`=1 and the select pattern `sel0_n`=0, `sel1`=1, `sel2_n`=0 starts a read. After that edge, and while `oe_n`=0, `dq_oe` is 1 and `rdata` is the stored word at the current burst address.
- R3: A load or advance in a write operation stores `wdata` at that cycle's burst address on the next enabled edge. The store is per byte: bit i of `lane_en`, sampled at the command edge, gates bits [8i+7:8i].
- R4: With `seq_mode`=1, the two low address bits of a burst are the start bits XOR 0, 1, 2, 3 in turn. A start of 01 gives 01, 00, 11, 10. The upper address bits stay fixed.
- R5: With `seq_mode`=0, the two low address bits are the start plus 0, 1, 2, 3 modulo 4. A start of 01 gives 01, 10, 11, 00.
- R6: During an advance (`adv`=1), the select inputs and `rd_wr` have no effect. The burst keeps the operation type of its load.
- R7: On an edge with `clk_hold`=1, no input is sampled, no state changes and nothing is written.
- R8: A load with any other select pattern deselects the device. `dq_oe` is 0 afterwards, and later advances neither drive data nor write.
- R9: `oe_n`=1 forces `dq_oe` to 0 and `rdata` to zero at once, without waiting for a clock edge.
- R10: While `snooze`=1, `dq_oe` is 0 and `rdata` is zero at once, all other inputs are ignored and stored words are retained. Once snooze ends, the device is deselected.
- R11: On the first enabled edge after snooze, a selected write load is dropped and the device is left deselected. `wr_err` is 1 for the following clock cycle only. A read load on that edge works as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_hold | input | 1 | 1 masks the clock edge |
| snooze | input | 1 | Asynchronous low-power hold, active high |
| seq_mode | input | 1 | Static burst order: 1 interleaved, 0 linear |
| adv | input | 1 | 0 loads a command, 1 advances the burst |
| rd_wr | input | 1 | On a load: 1 read, 0 write |
| sel0_n | input | 1 | Select, active low |
| sel1 | input | 1 | Select, active high |
| sel2_n | input | 1 | Select, active low |
| addr | input | ADDR_W | Word address, taken on a load |
| lane_en | input | DATA_W/8 | Byte lane write enables, active high |
| wdata | input | DATA_W | Write data, taken on the edge after the command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | DATA_W | Read data, zero when not driven |
| dq_oe | output | 1 | Data drive enable |
| wr_err | output | 1 | Write attempted on the first cycle after snooze |

## Verification
Directed bursts start at address bits 01 in both orders. Each beat of a write burst carries a distinct word, and the burst is then read back. This shows whether the counter applies XOR or modular addition and whether upper address bits leak. Partial lane masks applied over known contents show which bytes a write touches. Masked edges, deselect loads and advances with scrambled selects or `rd_wr` show that inputs are ignored at the right moments. A fixed-seed random phase mixes all commands with toggling `oe_n`, masking and rare snooze episodes, and compares every cycle with a bench model.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int unsigned BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic [BURST_W-1:0] start;
        logic [BURST_W-1:0] count;
    } burst_t;

    // next burst position: XOR walk or modular add
    function automatic logic [BURST_W-1:0] burst_pos(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] count,
        input logic               interleave
    );
        logic [BURST_W-1:0] pos;
        if (interleave) pos = start ^ count;
        else            pos = start + count;
        return pos;
    endfunction

    function automatic logic select_ok(
        input logic s0_n,
        input logic s1,
        input logic s2_n
    );
        return ~s0_n & s1 & ~s2_n;
    endfunction

endpackage

// File: rtl/bsram_cmd.sv
module bsram_cmd
    import bsram_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_hold,
    input  logic             snooze,
    input  logic             adv,
    input  logic             rd_wr,
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic             sel2_n,
    input  logic [LANES-1:0] lane_en,
    output op_e              op_q,
    output logic             load_go,
    output logic             step_go,
    output logic             commit,
    output logic [LANES-1:0] lanes_q,
    output logic             wr_err
);

    logic live;
    logic wake_q;
    logic sel_hit;

    assign live    = ~clk_hold & ~snooze;
    assign sel_hit = select_ok(sel0_n, sel1, sel2_n);
    assign load_go = live & ~adv;
    assign step_go = live & adv & (op_q != OP_IDLE);
    assign commit  = live & (op_q == OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_IDLE;
            wake_q  <= 1'b0;
            wr_err  <= 1'b0;
            lanes_q <= '0;
        end else begin
            wr_err <= 1'b0;
            if (snooze) begin
                op_q   <= OP_IDLE;
                wake_q <= 1'b1;
            end else if (!clk_hold) begin
                wake_q  <= 1'b0;
                lanes_q <= lane_en;
                if (!adv) begin
                    if (!sel_hit) begin
                        op_q <= OP_IDLE;
                    end else if (!rd_wr && wake_q) begin
                        op_q   <= OP_IDLE;
                        wr_err <= 1'b1;
                    end else begin
                        op_q <= rd_wr ? OP_READ : OP_WRITE;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_go,
    input  logic              step_go,
    input  logic              seq_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int unsigned HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0] hi_q;
    burst_t          bs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            bs_q <= '0;
        end else if (load_go) begin
            hi_q       <= addr[ADDR_W-1:BURST_W];
            bs_q.start <= addr[BURST_W-1:0];
            bs_q.count <= '0;
        end else if (step_go) begin
            bs_q.count <= bs_q.count + 1'b1;
        end
    end

    assign cur_addr = {hi_q, burst_pos(bs_q.start, bs_q.count, seq_mode)};

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_go,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W/8-1:0] wr_lanes,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_word
);

    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < DEPTH; k++) cells[k] <= 8'h00;
            end else if (wr_go && wr_lanes[g]) begin
                cells[wr_addr] <= wdata[8*g +: 8];
            end
        end

        assign rd_word[8*g +: 8] = cells[rd_addr];
    end

endmodule

// File: rtl/bsram_top.sv
module bsram_top
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_hold,
    input  logic                snooze,
    input  logic                seq_mode,
    input  logic                adv,
    input  logic                rd_wr,
    input  logic                sel0_n,
    input  logic                sel1,
    input  logic                sel2_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W/8-1:0] lane_en,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                oe_n,
    output logic [DATA_W-1:0]   rdata,
    output logic                dq_oe,
    output logic                wr_err
);

    localparam int unsigned LANES = DATA_W / 8;

    op_e               op_q;
    logic              load_go;
    logic              step_go;
    logic              commit;
    logic [LANES-1:0]  lanes_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] rd_word;

    bsram_cmd #(.LANES(LANES)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .clk_hold (clk_hold),
        .snooze   (snooze),
        .adv      (adv),
        .rd_wr    (rd_wr),
        .sel0_n   (sel0_n),
        .sel1     (sel1),
        .sel2_n   (sel2_n),
        .lane_en  (lane_en),
        .op_q     (op_q),
        .load_go  (load_go),
        .step_go  (step_go),
        .commit   (commit),
        .lanes_q  (lanes_q),
        .wr_err   (wr_err)
    );

    bsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .load_go  (load_go),
        .step_go  (step_go),
        .seq_mode (seq_mode),
        .addr     (addr),
        .cur_addr (cur_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_go    (commit),
        .wr_addr  (cur_addr),
        .wr_lanes (lanes_q),
        .wdata    (wdata),
        .rd_addr  (cur_addr),
        .rd_word  (rd_word)
    );

    assign dq_oe = (op_q == OP_READ) & ~oe_n & ~snooze;
    assign rdata = dq_oe ? rd_word : '0;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_hold,
    input logic              snooze,
    input logic              adv,
    input logic              rd_wr,
    input logic              sel0_n,
    input logic              sel1,
    input logic              sel2_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] rdata,
    input logic              dq_oe,
    input logic              wr_err,
    input logic [1:0]        op_q
);

    logic sel_good;
    assign sel_good = ~sel0_n & sel1 & ~sel2_n;

    // R9: output enable released while oe_n is high
    a_r9_oe_release: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    // R10: nothing driven during snooze
    a_r10_snooze_quiet: assert property (@(posedge clk) disable iff (rst)
        snooze |-> (!dq_oe && rdata == '0));

    // R7: masked edge leaves the operation untouched
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (rst)
        (clk_hold && !snooze) |=> $stable(op_q));

    // R8: a load with a bad select pattern releases the outputs
    a_r8_deselect: assert property (@(posedge clk) disable iff (rst)
        (!clk_hold && !snooze && !adv && !sel_good) |=> !dq_oe);

    // R11: flag only follows an enabled write load
    a_r11_wake_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_err && !$past(rst)) |-> $past(!adv && !rd_wr && !clk_hold && !snooze && sel_good));

endmodule

bind bsram_top bsram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_hold (clk_hold),
    .snooze   (snooze),
    .adv      (adv),
    .rd_wr    (rd_wr),
    .sel0_n   (sel0_n),
    .sel1     (sel1),
    .sel2_n   (sel2_n),
    .oe_n     (oe_n),
    .rdata    (rdata),
    .dq_oe    (dq_oe),
    .wr_err   (wr_err),
    .op_q     (op_q)
);

// File: tb/bsram_top_tb.sv
module bsram_top_tb;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NL = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_hold = 1'b0;
    logic          snooze = 1'b0;
    logic          seq_mode = 1'b1;
    logic          adv = 1'b0;
    logic          rd_wr = 1'b1;
    logic          sel0_n = 1'b1;
    logic          sel1 = 1'b0;
    logic          sel2_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] lane_en = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          dq_oe;
    logic          wr_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model state
    logic [DW-1:0] mm [DEPTH];
    int            m_op;      // 0 idle, 1 read, 2 write
    logic [AW-3:0] m_hi;
    logic [1:0]    m_start;
    logic [1:0]    m_cnt;
    logic [NL-1:0] m_lanes;
    logic          m_wake;
    logic          m_err;

    always #2.5 clk = ~clk;

    bsram_top #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .clk_hold(clk_hold), .snooze(snooze),
        .seq_mode(seq_mode), .adv(adv), .rd_wr(rd_wr), .sel0_n(sel0_n),
        .sel1(sel1), .sel2_n(sel2_n), .addr(addr), .lane_en(lane_en),
        .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .dq_oe(dq_oe),
        .wr_err(wr_err)
    );

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = seq_mode ? (m_start ^ m_cnt) : (m_start + m_cnt);
        return {m_hi, lo};
    endfunction

    function automatic logic exp_oe();
        return (m_op == 1) && !oe_n && !snooze;
    endfunction

    function automatic logic [DW-1:0] exp_data();
        return exp_oe() ? mm[m_addr()] : '0;
    endfunction

    task automatic model_edge();
        logic ok;
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mm[k] = '0;
            m_op = 0; m_hi = '0; m_start = '0; m_cnt = '0;
            m_lanes = '0; m_wake = 0; m_err = 0;
            return;
        end
        m_err = 0;
        if (snooze) begin
            m_op = 0; m_wake = 1;
            return;
        end
        if (clk_hold) return;
        if (m_op == 2) begin
            for (int i = 0; i < NL; i++)
                if (m_lanes[i]) mm[m_addr()][8*i +: 8] = wdata[8*i +: 8];
        end
        ok = !sel0_n && sel1 && !sel2_n;
        if (!adv) begin
            m_hi = addr[AW-1:2]; m_start = addr[1:0]; m_cnt = 0;
            if (!ok) m_op = 0;
            else if (!rd_wr && m_wake) begin m_op = 0; m_err = 1; end
            else m_op = rd_wr ? 1 : 2;
        end else if (m_op != 0) begin
            m_cnt = m_cnt + 1;
        end
        m_lanes = lane_en;
        m_wake = 0;
    endtask

    task automatic check(string tag);
        total++;
        if (dq_oe !== exp_oe() || rdata !== exp_data() || wr_err !== m_err) begin
            bad++;
            $display("FAIL %s: oe=%0b data=%h err=%0b expected oe=%0b data=%h err=%0b",
                     tag, dq_oe, rdata, wr_err, exp_oe(), exp_data(), m_err);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        #1;
        check(tag);
    endtask

    task automatic cmd(bit a, bit rw, logic [AW-1:0] ad, logic [NL-1:0] ln, logic [DW-1:0] wd);
        adv = a; rd_wr = rw; addr = ad; lane_en = ln; wdata = wd;
        sel0_n = 0; sel1 = 1; sel2_n = 0;
    endtask

    task automatic word_check(string tag, logic [DW-1:0] v);
        total++;
        if (rdata !== v) begin
            bad++;
            $display("FAIL %s: data=%h expected %h", tag, rdata, v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5 * 150000);
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0C1A));
        repeat (2) tick("R1 reset");
        rst = 0;
        #1 check("R1 reset state");

        // R3 full word write then R2 read back
        cmd(0, 0, 6'd5, 4'hF, '0);        tick("R3 write load");
        cmd(0, 1, 6'd5, 4'h0, 32'hDEADBEEF); tick("R2 read after write");
        word_check("R3 full word", 32'hDEADBEEF);

        // R3 partial lanes
        cmd(0, 0, 6'd5, 4'b0101, '0);     tick("R3 lane load");
        cmd(0, 1, 6'd5, 4'h0, 32'h11223344); tick("R3 lane commit");
        word_check("R3 lanes 0101", 32'hDE22BE44);

        // R4 interleaved write burst from start 01, distinct beats
        seq_mode = 1;
        cmd(0, 0, 6'h09, 4'hF, '0);       tick("R4 burst load");
        cmd(1, 0, 6'h00, 4'hF, 32'hA0A0A000); tick("R4 beat0");
        cmd(1, 0, 6'h00, 4'hF, 32'hA0A0A001); tick("R4 beat1");
        cmd(1, 0, 6'h00, 4'hF, 32'hA0A0A002); tick("R4 beat2");
        cmd(0, 1, 6'h09, 4'h0, 32'hA0A0A003); tick("R4 read load");
        word_check("R4 beat at 09", 32'hA0A0A000);
        cmd(1, 1, 6'h00, 4'h0, '0); tick("R4 step1"); word_check("R4 addr 08", 32'hA0A0A001);
        // R6: scrambled selects and rd_wr during advance
        sel0_n = 1; sel1 = 0; rd_wr = 0;
        tick("R6 step2 ignore"); word_check("R6 R4 addr 0B", 32'hA0A0A002);
        tick("R6 step3 ignore"); word_check("R6 R4 addr 0A", 32'hA0A0A003);

        // R5 linear: read same block from start 01 -> 09, 0A, 0B, 08
        seq_mode = 0;
        cmd(0, 1, 6'h09, 4'h0, '0); tick("R5 load"); word_check("R5 addr 09", 32'hA0A0A000);
        cmd(1, 1, 6'h00, 4'h0, '0); tick("R5 step1"); word_check("R5 addr 0A", 32'hA0A0A003);
        tick("R5 step2"); word_check("R5 addr 0B", 32'hA0A0A002);
        tick("R5 step3"); word_check("R5 addr 08", 32'hA0A0A001);
        tick("R5 wrap");  word_check("R5 wrap 09", 32'hA0A0A000);

        // R9 async oe
        oe_n = 1; #1 check("R9 oe high");
        oe_n = 0; #1 check("R9 oe low");

        // R7 masked edge with a write load on the pins
        clk_hold = 1;
        cmd(0, 0, 6'd5, 4'hF, 32'h0);
        tick("R7 masked"); tick("R7 masked again");
        clk_hold = 0;
        cmd(0, 1, 6'd5, 4'h0, '0); tick("R7 read back");
        word_check("R7 unchanged", 32'hDE22BE44);

        // R8 deselect then advances with write data
        cmd(0, 0, 6'd5, 4'hF, '0); sel2_n = 1; tick("R8 deselect load");
        cmd(1, 0, 6'd5, 4'hF, 32'h0BAD0BAD); tick("R8 advance idle");
        cmd(0, 1, 6'd5, 4'h0, 32'h0BAD0BAD); tick("R8 read");
        word_check("R8 no write", 32'hDE22BE44);

        // R10 snooze mid-read
        snooze = 1; #1 check("R10 release");
        cmd(0, 0, 6'd5, 4'hF, 32'hFFFFFFFF);
        tick("R10 snooze edge"); tick("R10 snooze edge2");
        snooze = 0;
        #1 check("R10 deselected after");
        // R11 write on wake edge dropped
        cmd(0, 0, 6'd5, 4'hF, 32'h0); tick("R11 wake write flag");
        cmd(0, 1, 6'd5, 4'h0, 32'h77777777); tick("R11 flag clears");
        word_check("R11 R10 retained", 32'hDE22BE44);
        // R11 read allowed on wake edge
        snooze = 1; tick("R10 snooze again"); snooze = 0;
        cmd(0, 1, 6'h09, 4'h0, '0); tick("R11 wake read");
        word_check("R11 wake read data", 32'hA0A0A000);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            if (n % 500 == 0) seq_mode = $urandom_range(0, 1);
            r = $urandom_range(0, 99);
            adv = $urandom_range(0, 1);
            rd_wr = $urandom_range(0, 1);
            addr = $urandom;
            lane_en = $urandom;
            wdata = $urandom;
            sel0_n = (r < 8); sel1 = !(r >= 8 && r < 12); sel2_n = (r >= 12 && r < 15);
            clk_hold = ($urandom_range(0, 7) == 0);
            snooze = ($urandom_range(0, 59) == 0);
            oe_n = ($urandom_range(0, 5) == 0);
            #1 check("R9 R10 async");
            tick("R2 random");
        end
        snooze = 0; clk_hold = 0; oe_n = 0;
        finish_run();
    end

endmodule